// File: doc/BRIEF.md
# Header-Routed Register Packet Engine

This block sits on one board of a daisy chain of boards joined by serial links. Packets arrive from upstream as a stream of 32-bit words with start and end flags. The leading word of each packet is a routing header, and the board acts on it in one of three ways:

- **Local header:** the packet is meant for this board. The block runs the register write or read it carries on its register-file port.
- **Next-link header:** the block removes that header and passes the rest of the packet to the next-link port, with the following header now in front.
- **Any other header:** the packet is discarded and a sticky error flag is set.

A local read builds a reply in the same header, address and command layout, followed by the requested words, and sends it back upstream. A stack of next-link headers lets a host reach a register several boards down the chain.

A local packet is laid out as follows:

| Word | Content |
|------|---------|
| 0 | Routing header |
| 1 | Register address |
| 2 | Command |
| 3 onward | Write data, present only for a write |

A board's status register lives inside the block. All other addresses go to the external register-file port.

Top module: `hdr_route_engine`

## Requirements
- R1: A packet whose leading word has bits 7:0 equal to 0x02 is consumed locally, and none of its words appear on the next-link port.
- R2: In a local packet, word 1 is the address and word 2 is the command. Command bit 31 = 0 means write. Each data word after the command produces one register write, the first at the address and each later one at the next higher address.
- R3: Command bit 31 = 1 means read, and command bits 15:0 hold the count n. The reply is: header 0x02, the address, a command word with bit 31 = 1 and n in bits 15:0, then n words read from address, address+1 and so on. Start is flagged on the first reply word and end on the last.
- R4: A read with n = 0 produces no reply words.
- R5: A leading word with bits 7:0 equal to 0x05 is removed. The remaining words go out on the next-link port unchanged, with start flagged on the first of them and end mirroring the input end flag.
- R6: Any other leading header value discards the whole packet, with no register access and no forwarding. It also sets status bit 0, which stays set until reset.
- R7: Address 0x14 is the status register, with bit 0 holding the unknown-header error. Reads of 0x14 return it. Writes to 0x14 never reach the register-file port.
- R8: While a reply is pending on the upstream return port, the block accepts no input words. A stalled reply word holds its value until it is taken.
- R9: While forwarding, the block accepts an input word only when the next-link port is ready.
- R10: After reset the block is idle: input ready is high, and both output valids and the error flag are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream word accepted when high with valid |
| in_data | input | DW | Upstream word |
| in_sop | input | 1 | Upstream start of packet |
| in_eop | input | 1 | Upstream end of packet |
| nx_valid | output | 1 | Next-link word valid |
| nx_ready | input | 1 | Next-link ready |
| nx_data | output | DW | Next-link word |
| nx_sop | output | 1 | Next-link start of packet |
| nx_eop | output | 1 | Next-link end of packet |
| rp_valid | output | 1 | Reply word valid |
| rp_ready | input | 1 | Reply ready |
| rp_data | output | DW | Reply word |
| rp_sop | output | 1 | Reply start of packet |
| rp_eop | output | 1 | Reply end of packet |
| rf_addr | output | ADDR_W | Register-file address |
| rf_we | output | 1 | Register write strobe |
| rf_wdata | output | DW | Register write data |
| rf_re | output | 1 | Register read strobe (data sampled combinationally) |
| rf_rdata | input | DW | Register read data |

## Verification
A parse state that slips by one word shows within a single packet. Data lands at the wrong register, the reply's address or command word is wrong, or forwarded words lose the start flag on the following board.

A wrong address counter shows in the second word of a multi-word write or read. A lost error flag appears at the next status read. A state that fails to return to idle leaves input ready low, so the next packet stalls and the whole chain visibly stops.

// File: rtl/hdr_route_engine.sv
`timescale 1ns/1ps
module hdr_route_engine #(
  parameter int DW = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W = 16,
  parameter logic [7:0] LOCAL_HDR = 8'h02,
  parameter logic [7:0] NEXT_HDR = 8'h05,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              nx_valid,
  input  logic              nx_ready,
  output logic [DW-1:0]     nx_data,
  output logic              nx_sop,
  output logic              nx_eop,
  output logic              rp_valid,
  input  logic              rp_ready,
  output logic [DW-1:0]     rp_data,
  output logic              rp_sop,
  output logic              rp_eop,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_we,
  output logic [DW-1:0]     rf_wdata,
  output logic              rf_re,
  input  logic [DW-1:0]     rf_rdata
);
  localparam int RD_BIT = DW - 1;

  typedef enum logic [3:0] {
    S_HDR, S_FWD, S_ADDR, S_CMD, S_WR, S_DROP, S_RPH, S_RPA, S_RPC, S_RPD
  } st_t;

  st_t              st;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic              fwd_first, err, rd_pend;
  logic              in_fire, rp_fire, in_parse, status_hit;
  logic [7:0]        code;
  logic [DW-1:0]     rd_word;

  assign code       = in_data[7:0];
  assign in_parse   = (st == S_HDR) || (st == S_ADDR) || (st == S_CMD) ||
                      (st == S_WR) || (st == S_DROP);
  assign in_ready   = (st == S_FWD) ? nx_ready : in_parse;
  assign in_fire    = in_valid && in_ready;
  assign status_hit = (addr == STATUS_ADDR);

  assign nx_valid = (st == S_FWD) && in_valid;
  assign nx_data  = in_data;
  assign nx_sop   = fwd_first;
  assign nx_eop   = in_eop;

  assign rp_valid = (st == S_RPH) || (st == S_RPA) || (st == S_RPC) || (st == S_RPD);
  assign rp_fire  = rp_valid && rp_ready;
  assign rp_sop   = (st == S_RPH);
  assign rp_eop   = (st == S_RPD) && (cnt == CNT_W'(1));
  assign rd_word  = status_hit ? {{(DW-1){1'b0}}, err} : rf_rdata;

  always_comb begin
    case (st)
      S_RPH:   rp_data = {{(DW-8){1'b0}}, LOCAL_HDR};
      S_RPA:   rp_data = {{(DW-ADDR_W){1'b0}}, addr};
      S_RPC:   rp_data = {1'b1, {(DW-1-CNT_W){1'b0}}, cnt};
      S_RPD:   rp_data = rd_word;
      default: rp_data = '0;
    endcase
  end

  assign rf_addr  = addr;
  assign rf_wdata = in_data;
  assign rf_we    = (st == S_WR) && in_fire && !status_hit;
  assign rf_re    = (st == S_RPD) && rp_fire && !status_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_HDR;
      addr      <= '0;
      cnt       <= '0;
      fwd_first <= 1'b0;
      err       <= 1'b0;
      rd_pend   <= 1'b0;
    end else begin
      case (st)
        S_HDR: if (in_fire) begin
          rd_pend <= 1'b0;
          if (code == LOCAL_HDR) begin
            if (!in_eop) st <= S_ADDR;
          end else if (code == NEXT_HDR) begin
            fwd_first <= 1'b1;
            if (!in_eop) st <= S_FWD;
          end else begin
            err <= 1'b1;
            if (!in_eop) st <= S_DROP;
          end
        end
        S_FWD: if (in_fire) begin
          fwd_first <= 1'b0;
          if (in_eop) st <= S_HDR;
        end
        S_ADDR: if (in_fire) begin
          addr <= in_data[ADDR_W-1:0];
          st   <= in_eop ? S_HDR : S_CMD;
        end
        S_CMD: if (in_fire) begin
          cnt <= in_data[CNT_W-1:0];
          if (in_data[RD_BIT]) begin
            if (!in_eop) begin
              rd_pend <= 1'b1;
              st      <= S_DROP;
            end else begin
              st <= (in_data[CNT_W-1:0] != '0) ? S_RPH : S_HDR;
            end
          end else begin
            st <= in_eop ? S_HDR : S_WR;
          end
        end
        S_WR: if (in_fire) begin
          addr <= addr + ADDR_W'(1);
          if (in_eop) st <= S_HDR;
        end
        S_DROP: if (in_fire && in_eop)
          st <= (rd_pend && cnt != '0) ? S_RPH : S_HDR;
        S_RPH: if (rp_fire) st <= S_RPA;
        S_RPA: if (rp_fire) st <= S_RPC;
        S_RPC: if (rp_fire) st <= S_RPD;
        S_RPD: if (rp_fire) begin
          addr <= addr + ADDR_W'(1);
          cnt  <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) st <= S_HDR;
        end
        default: st <= S_HDR;
      endcase
    end
  end

  logic unused_sop;
  assign unused_sop = in_sop;
endmodule

// File: rtl/hdr_route_engine_chk.sv
`timescale 1ns/1ps
module hdr_route_engine_chk #(parameter int DW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          nx_valid,
  input logic          nx_ready,
  input logic          rp_valid,
  input logic          rp_ready,
  input logic [DW-1:0] rp_data,
  input logic          rp_sop,
  input logic          rp_eop,
  input logic          rf_we,
  input logic          rf_re,
  input logic          err
);
  p_reply_blocks_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid |-> !in_ready);
  p_reply_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid && !rp_ready |=> rp_valid && $stable(rp_data));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_fwd_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nx_valid |-> (in_ready == nx_ready));
  p_we_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> in_valid && in_ready);
  p_one_rf_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && rf_re));
  p_reply_framing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid && rp_sop |-> !rp_eop);
endmodule

bind hdr_route_engine hdr_route_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .nx_valid(nx_valid), .nx_ready(nx_ready), .rp_valid(rp_valid),
  .rp_ready(rp_ready), .rp_data(rp_data), .rp_sop(rp_sop), .rp_eop(rp_eop),
  .rf_we(rf_we), .rf_re(rf_re), .err(err)
);

// File: tb/hdr_route_engine_tb.sv
`timescale 1ns/1ps
module hdr_route_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        a_valid = 0, a_sop = 0, a_eop = 0, a_ready;
  logic [31:0] a_data = '0;
  logic        l_valid, l_ready, l_sop, l_eop;
  logic [31:0] l_data;
  logic        s_valid, s_sop, s_eop, s_ready = 1'b1;
  logic [31:0] s_data;
  logic        r1_valid, r1_sop, r1_eop, r1_ready = 1'b1;
  logic [31:0] r1_data;
  logic        r2_valid, r2_sop, r2_eop;
  logic [31:0] r2_data;
  logic [15:0] f1_addr, f2_addr;
  logic        f1_we, f1_re, f2_we, f2_re;
  logic [31:0] f1_wdata, f2_wdata, f1_rdata, f2_rdata;
  logic [31:0] mem1 [0:255];
  logic [31:0] mem2 [0:255];

  assign f1_rdata = mem1[f1_addr[7:0]];
  assign f2_rdata = mem2[f2_addr[7:0]];
  always @(posedge clk) if (f1_we) mem1[f1_addr[7:0]] <= f1_wdata;
  always @(posedge clk) if (f2_we) mem2[f2_addr[7:0]] <= f2_wdata;

  hdr_route_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(a_valid), .in_ready(a_ready), .in_data(a_data), .in_sop(a_sop), .in_eop(a_eop),
    .nx_valid(l_valid), .nx_ready(l_ready), .nx_data(l_data), .nx_sop(l_sop), .nx_eop(l_eop),
    .rp_valid(r1_valid), .rp_ready(r1_ready), .rp_data(r1_data), .rp_sop(r1_sop), .rp_eop(r1_eop),
    .rf_addr(f1_addr), .rf_we(f1_we), .rf_wdata(f1_wdata), .rf_re(f1_re), .rf_rdata(f1_rdata));

  hdr_route_engine u_b2 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(l_valid), .in_ready(l_ready), .in_data(l_data), .in_sop(l_sop), .in_eop(l_eop),
    .nx_valid(s_valid), .nx_ready(s_ready), .nx_data(s_data), .nx_sop(s_sop), .nx_eop(s_eop),
    .rp_valid(r2_valid), .rp_ready(1'b1), .rp_data(r2_data), .rp_sop(r2_sop), .rp_eop(r2_eop),
    .rf_addr(f2_addr), .rf_we(f2_we), .rf_wdata(f2_wdata), .rf_re(f2_re), .rf_rdata(f2_rdata));

  logic [31:0] rd [0:63];
  logic        rs [0:63];
  logic        re [0:63];
  int rn = 0;
  logic [31:0] sd [0:63];
  logic        ss [0:63];
  int sn = 0;
  int r2n = 0;
  always @(posedge clk) begin
    if (r1_valid && r1_ready && rn < 64) begin
      rd[rn] <= r1_data; rs[rn] <= r1_sop; re[rn] <= r1_eop; rn <= rn + 1;
    end
    if (s_valid && s_ready && sn < 64) begin
      sd[sn] <= s_data; ss[sn] <= s_sop; sn <= sn + 1;
    end
    if (r2_valid) r2n <= r2n + 1;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] pk [0:7];
  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      bit hs = 0;
      while (!hs) begin
        @(negedge clk);
        a_valid = 1; a_data = pk[i]; a_sop = (i == 0); a_eop = (i == n - 1);
        #3 hs = a_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    a_valid = 0; a_sop = 0; a_eop = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  localparam logic [31:0] WR_VEC [4][2] = '{
    '{32'h0000_0004, 32'h1111_1111},
    '{32'h0000_0005, 32'hA5A5_0F0F},
    '{32'h0000_00FF, 32'hFFFF_FFFF},
    '{32'h0000_0000, 32'h8000_0001}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int b, s0;
    for (int i = 0; i < 256; i++) begin mem1[i] = '0; mem2[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(a_ready == 1'b1, "R10 in_ready", {31'b0, a_ready}, 32'd1);
    chk(r1_valid == 1'b0, "R10 rp_valid", {31'b0, r1_valid}, 32'd0);
    chk(l_valid == 1'b0, "R10 nx_valid", {31'b0, l_valid}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    for (int v = 0; v < 4; v++) begin
      s0 = sn;
      pk[0] = 32'h02; pk[1] = WR_VEC[v][0]; pk[2] = 32'h0; pk[3] = WR_VEC[v][1];
      send(4); idle(3);
      chk(mem1[WR_VEC[v][0][7:0]] == WR_VEC[v][1], "R2 local write", mem1[WR_VEC[v][0][7:0]], WR_VEC[v][1]);
      chk(mem2[WR_VEC[v][0][7:0]] == 32'h0 && sn == s0, "R1 not forwarded", mem2[WR_VEC[v][0][7:0]], 32'h0);
    end

    pk[0] = 32'h02; pk[1] = 32'h20; pk[2] = 32'h0;
    pk[3] = 32'hAAAA_0001; pk[4] = 32'hBBBB_0002; pk[5] = 32'hCCCC_0003;
    send(6); idle(3);
    chk(mem1[8'h20] == 32'hAAAA_0001, "R2 burst word0", mem1[8'h20], 32'hAAAA_0001);
    chk(mem1[8'h21] == 32'hBBBB_0002, "R2 burst word1", mem1[8'h21], 32'hBBBB_0002);
    chk(mem1[8'h22] == 32'hCCCC_0003, "R2 burst word2", mem1[8'h22], 32'hCCCC_0003);

    pk[0] = 32'h05; pk[1] = 32'h02; pk[2] = 32'h30; pk[3] = 32'h0; pk[4] = 32'hD00D_F00D;
    send(5); idle(4);
    chk(mem2[8'h30] == 32'hD00D_F00D, "R5 forwarded write", mem2[8'h30], 32'hD00D_F00D);
    chk(mem1[8'h30] == 32'h0, "R5 board1 untouched", mem1[8'h30], 32'h0);

    s0 = sn;
    pk[0] = 32'h05; pk[1] = 32'h05; pk[2] = 32'h02; pk[3] = 32'h44; pk[4] = 32'h0; pk[5] = 32'h77;
    send(6); idle(4);
    chk(sn - s0 == 4, "R5 strip two headers count", sn - s0, 4);
    chk(sd[s0] == 32'h02 && ss[s0], "R5 leading word with sop", sd[s0], 32'h02);
    chk(!ss[s0 + 1] && sd[s0 + 3] == 32'h77, "R5 body unchanged", sd[s0 + 3], 32'h77);

    b = rn;
    pk[0] = 32'h02; pk[1] = 32'h14; pk[2] = 32'h8000_0001;
    send(3); idle(8);
    chk(rd[b + 3] == 32'h0, "R7 status clear at start", rd[b + 3], 32'h0);

    b = rn;
    r1_ready = 1'b0;
    pk[0] = 32'h02; pk[1] = 32'h20; pk[2] = 32'h8000_0003;
    send(3); idle(3);
    chk(r1_valid == 1'b1, "R8 reply pending", {31'b0, r1_valid}, 32'd1);
    chk(a_ready == 1'b0, "R8 input blocked during reply", {31'b0, a_ready}, 32'd0);
    chk(r1_data == 32'h02, "R8 held header word", r1_data, 32'h02);
    r1_ready = 1'b1;
    idle(10);
    chk(rn - b == 6, "R3 reply length", rn - b, 6);
    chk(rd[b] == 32'h02 && rs[b], "R3 reply header", rd[b], 32'h02);
    chk(rd[b + 1] == 32'h20, "R3 reply address", rd[b + 1], 32'h20);
    chk(rd[b + 2] == 32'h8000_0003, "R3 reply command", rd[b + 2], 32'h8000_0003);
    chk(rd[b + 3] == 32'hAAAA_0001, "R3 reply data0", rd[b + 3], 32'hAAAA_0001);
    chk(rd[b + 5] == 32'hCCCC_0003 && re[b + 5] && !re[b + 4], "R3 reply data2 eop", rd[b + 5], 32'hCCCC_0003);

    b = rn;
    pk[0] = 32'h02; pk[1] = 32'h20; pk[2] = 32'h8000_0000;
    send(3); idle(6);
    chk(rn == b, "R4 zero-count read silent", rn - b, 0);
    chk(a_ready == 1'b1, "R4 idle after zero read", {31'b0, a_ready}, 32'd1);

    s0 = sn;
    pk[0] = 32'h33; pk[1] = 32'h40; pk[2] = 32'h0; pk[3] = 32'hDEAD_BEEF;
    send(4); idle(4);
    chk(mem1[8'h40] == 32'h0 && mem2[8'h40] == 32'h0, "R6 dropped no write", mem1[8'h40], 32'h0);
    chk(sn == s0, "R6 dropped not forwarded", sn - s0, 0);
    b = rn;
    pk[0] = 32'h02; pk[1] = 32'h14; pk[2] = 32'h8000_0001;
    send(3); idle(8);
    chk(rd[b + 3] == 32'h1, "R6 R7 status error bit", rd[b + 3], 32'h1);

    pk[0] = 32'h02; pk[1] = 32'h14; pk[2] = 32'h0; pk[3] = 32'h5555_5555;
    send(4); idle(3);
    chk(mem1[8'h14] == 32'h0, "R7 status write kept off port", mem1[8'h14], 32'h0);
    b = rn;
    pk[0] = 32'h02; pk[1] = 32'h14; pk[2] = 32'h8000_0001;
    send(3); idle(8);
    chk(rd[b + 3] == 32'h1, "R6 error sticky", rd[b + 3], 32'h1);

    s_ready = 1'b0;
    s0 = sn;
    pk[0] = 32'h05; pk[1] = 32'h05; pk[2] = 32'h02; pk[3] = 32'h50; pk[4] = 32'h0; pk[5] = 32'h99;
    fork
      send(6);
      begin
        idle(6);
        chk(a_ready == 1'b0, "R9 forwarding stalls input", {31'b0, a_ready}, 32'd0);
        chk(sn == s0, "R9 nothing passes while not ready", sn - s0, 0);
        s_ready = 1'b1;
      end
    join
    idle(4);
    chk(sn - s0 == 4 && sd[s0 + 3] == 32'h99, "R9 packet delivered after release", sd[s0 + 3], 32'h99);
    chk(r2n == 0, "R1 board2 sent no reply", r2n, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule